// File: doc/BRIEF.md
# Endian-Selectable Bus Width Matcher

This block sits on the read side of a FIFO that stores 36-bit long words and presents that data on an output bus whose usable width is 36, 18 or 9 bits. Two static configuration inputs choose the width. In the narrow modes each long word leaves as a series of pieces: two 18-bit words or four 9-bit bytes. The FIFO is popped only when the last piece of the current long word has been read. In long-word mode every read pops the FIFO and the full word appears unchanged.

The order of the pieces comes from a shared endian pin. The block samples that pin while master reset is held and keeps the value until the next reset. A latched high sends the most significant piece first. A latched low sends the least significant piece first. A read takes effect on a rising clock edge only when chip select is low, read enable is high and the FIFO reports valid data. The FIFO's valid indication is passed through unchanged as the output valid flag.

Top module: `busWidthMatcher`

## Requirements
- R1: With narrowSel low (long-word mode), outData equals fifoData, and every accepted read asserts fifoPop in that cycle.
- R2: With narrowSel high and sizeSel high (byte mode), outData[8:0] shows one 9-bit lane of the head word, where lane n is fifoData[9n+8:9n]. Each accepted read moves to the next lane, and fifoPop is asserted only on the fourth read of a word.
- R3: With narrowSel high and sizeSel low (word mode), outData[17:0] shows one 18-bit half of the head word, where half n is fifoData[18n+17:18n]. fifoPop is asserted only on the second read of a word.
- R4: The level of endianSel during reset sets the order of the pieces. High sends the highest lane or half first, ending at lane 0. Low sends lane 0 first, rising from there.
- R5: Changes on endianSel after reset is released have no effect on the order of the pieces.
- R6: A clock edge with selN high or rdEn low is not a read: fifoPop stays low and the piece position is kept.
- R7: In byte mode outData[35:9] is zero, and in word mode outData[35:18] is zero.
- R8: outValid follows fifoValid. While fifoValid is low no read is accepted, fifoPop stays low and the piece position is kept.
- R9: After reset the piece position is the first piece, and fifoPop is low when no read is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output-side clock |
| rstN | input | 1 | Master reset, active low, synchronous |
| endianSel | input | 1 | Piece order, sampled only while rstN is low (1 = most significant first) |
| narrowSel | input | 1 | 1 = narrow output (byte or word), 0 = full long word; static |
| sizeSel | input | 1 | In narrow mode, 1 = byte and 0 = word; static |
| selN | input | 1 | Chip select, active low |
| rdEn | input | 1 | Read enable, active high |
| fifoData | input | 36 | Head long word from the FIFO |
| fifoValid | input | 1 | The FIFO holds a word at its head |
| fifoPop | output | 1 | Pop request to the FIFO, one cycle per consumed long word |
| outData | output | 36 | Output data, with unused upper bits set to zero |
| outValid | output | 1 | Pass-through of fifoValid |

## Verification
Each long word the bench feeds has a different value in every 9-bit lane. A piece taken from the wrong lane, or pieces sent in the wrong order, therefore show up as a value mismatch, and the zero upper bits are checked at the same time. Byte, word and long-word modes are each run with both endian settings. In every run the endian pin is flipped right after reset, which separates a latched order from one that follows the live pin. Reads are also blocked by chip select, by read enable and by an empty FIFO, both in the middle of a word and on its last piece. These cases confirm that a blocked read neither pops the FIFO nor moves the piece position.

// File: rtl/bwm_pkg.sv
`timescale 1ns/1ps
package bwm_pkg;
  localparam int BYTE_W_DEF = 9;
  localparam int LANES_DEF  = 4;
  localparam int IDX_W      = $clog2(LANES_DEF);

  typedef enum logic [1:0] {
    MODE_LONG = 2'd0,
    MODE_WORD = 2'd1,
    MODE_BYTE = 2'd2
  } widthMode_t;

  typedef struct packed {
    widthMode_t       mode;
    logic             bigEnd;
    logic [IDX_W-1:0] pieceIdx;
  } dpCtrl_t;
endpackage

// File: rtl/bwm_ctrl.sv
`timescale 1ns/1ps
module bwm_ctrl
  import bwm_pkg::*;
#(
  parameter int LANES = LANES_DEF
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    endianSel,
  input  logic    narrowSel,
  input  logic    sizeSel,
  input  logic    selN,
  input  logic    rdEn,
  input  logic    fifoValid,
  output logic    fifoPop,
  output dpCtrl_t dpCtrl
);
  localparam int WORD_LANES = LANES / 2;

  logic             bigEndQ;
  logic [IDX_W-1:0] pieceQ;
  logic [IDX_W-1:0] lastIdx;
  widthMode_t       mode;
  logic             accept;
  logic             lastPiece;

  always_comb begin
    if (!narrowSel)   mode = MODE_LONG;
    else if (sizeSel) mode = MODE_BYTE;
    else              mode = MODE_WORD;
  end

  always_comb begin
    unique case (mode)
      MODE_BYTE: lastIdx = IDX_W'(LANES - 1);
      MODE_WORD: lastIdx = IDX_W'(WORD_LANES - 1);
      default:   lastIdx = '0;
    endcase
  end

  assign accept    = !selN && rdEn && fifoValid;
  assign lastPiece = (pieceQ == lastIdx);
  assign fifoPop   = accept && lastPiece;

  // Endian order is captured on every edge while reset is held.
  always_ff @(posedge clk) begin
    if (!rstN) bigEndQ <= endianSel;
  end

  always_ff @(posedge clk) begin
    if (!rstN)          pieceQ <= '0;
    else if (accept) begin
      if (lastPiece)    pieceQ <= '0;
      else              pieceQ <= pieceQ + IDX_W'(1);
    end
  end

  assign dpCtrl.mode     = mode;
  assign dpCtrl.bigEnd   = bigEndQ;
  assign dpCtrl.pieceIdx = pieceQ;
endmodule

// File: rtl/bwm_datapath.sv
`timescale 1ns/1ps
module bwm_datapath
  import bwm_pkg::*;
#(
  parameter  int BYTE_W = BYTE_W_DEF,
  parameter  int LANES  = LANES_DEF,
  localparam int LONG_W = BYTE_W * LANES
) (
  input  logic [LONG_W-1:0] fifoData,
  input  dpCtrl_t           dpCtrl,
  output logic [LONG_W-1:0] outData
);
  localparam int WORD_W     = 2 * BYTE_W;
  localparam int WORD_LANES = LANES / 2;
  localparam int WIDX_W     = $clog2(WORD_LANES);

  logic [BYTE_W-1:0] byteLane [LANES];
  logic [WORD_W-1:0] wordLane [WORD_LANES];
  logic [IDX_W-1:0]  byteSel;
  logic [WIDX_W-1:0] wordSel;

  for (genvar g = 0; g < LANES; g++) begin : g_byte
    assign byteLane[g] = fifoData[g*BYTE_W +: BYTE_W];
  end

  for (genvar h = 0; h < WORD_LANES; h++) begin : g_word
    assign wordLane[h] = fifoData[h*WORD_W +: WORD_W];
  end

  always_comb begin
    if (dpCtrl.bigEnd) begin
      byteSel = IDX_W'(LANES - 1) - dpCtrl.pieceIdx;
      wordSel = WIDX_W'(WORD_LANES - 1) - dpCtrl.pieceIdx[WIDX_W-1:0];
    end else begin
      byteSel = dpCtrl.pieceIdx;
      wordSel = dpCtrl.pieceIdx[WIDX_W-1:0];
    end
  end

  always_comb begin
    unique case (dpCtrl.mode)
      MODE_BYTE: outData = LONG_W'(byteLane[byteSel]);
      MODE_WORD: outData = LONG_W'(wordLane[wordSel]);
      default:   outData = fifoData;
    endcase
  end
endmodule

// File: rtl/busWidthMatcher.sv
`timescale 1ns/1ps
module busWidthMatcher
  import bwm_pkg::*;
#(
  parameter  int BYTE_W = BYTE_W_DEF,
  parameter  int LANES  = LANES_DEF,
  localparam int LONG_W = BYTE_W * LANES
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              endianSel,
  input  logic              narrowSel,
  input  logic              sizeSel,
  input  logic              selN,
  input  logic              rdEn,
  input  logic [LONG_W-1:0] fifoData,
  input  logic              fifoValid,
  output logic              fifoPop,
  output logic [LONG_W-1:0] outData,
  output logic              outValid
);
  dpCtrl_t dpCtrl;

  bwm_ctrl #(.LANES(LANES)) ctrl (
    .clk(clk), .rstN(rstN), .endianSel(endianSel),
    .narrowSel(narrowSel), .sizeSel(sizeSel),
    .selN(selN), .rdEn(rdEn), .fifoValid(fifoValid),
    .fifoPop(fifoPop), .dpCtrl(dpCtrl)
  );

  bwm_datapath #(.BYTE_W(BYTE_W), .LANES(LANES)) dp (
    .fifoData(fifoData), .dpCtrl(dpCtrl), .outData(outData)
  );

  assign outValid = fifoValid;
endmodule

// File: rtl/bwm_checker.sv
`timescale 1ns/1ps
module bwm_checker #(
  parameter int BYTE_W = 9,
  parameter int LONG_W = 36
) (
  input logic              clk,
  input logic              rstN,
  input logic              narrowSel,
  input logic              sizeSel,
  input logic              selN,
  input logic              rdEn,
  input logic              fifoValid,
  input logic [LONG_W-1:0] fifoData,
  input logic              fifoPop,
  input logic [LONG_W-1:0] outData,
  input logic              outValid
);
  logic accept;
  assign accept = !selN && rdEn && fifoValid;

  // R1: long-word mode pops on every accepted read
  a_r1_long_pop: assert property (@(posedge clk) disable iff (!rstN)
    (!narrowSel && accept) |-> fifoPop);

  // R2 / R3: a narrow pop is never followed directly by another pop
  a_r2_no_back_to_back_pop: assert property (@(posedge clk) disable iff (!rstN)
    (narrowSel && fifoPop) |=> !fifoPop);

  // R6: no pop without chip select and enable
  a_r6_no_pop_when_gated: assert property (@(posedge clk) disable iff (!rstN)
    (selN || !rdEn) |-> !fifoPop);

  // R8: no pop from an empty FIFO, valid passes straight through
  a_r8_no_pop_empty: assert property (@(posedge clk) disable iff (!rstN)
    !fifoValid |-> (!fifoPop && !outValid));

  // R7: upper bits are zero in byte mode
  a_r7_byte_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    (narrowSel && sizeSel) |-> (outData[LONG_W-1:BYTE_W] == '0));

  // R7: upper bits are zero in word mode
  a_r7_word_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    (narrowSel && !sizeSel) |-> (outData[LONG_W-1:2*BYTE_W] == '0));

  // R5 / R6: with no read and steady input data the output holds
  a_r5_output_holds: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(accept) && $stable(fifoData)) |-> $stable(outData));
endmodule

bind busWidthMatcher bwm_checker #(.BYTE_W(BYTE_W), .LONG_W(LONG_W)) chk (
  .clk(clk), .rstN(rstN), .narrowSel(narrowSel), .sizeSel(sizeSel),
  .selN(selN), .rdEn(rdEn), .fifoValid(fifoValid), .fifoData(fifoData),
  .fifoPop(fifoPop), .outData(outData), .outValid(outValid)
);

// File: tb/busWidthMatcher_test.sv
`timescale 1ns/1ps
module busWidthMatcher_test;
  logic        clk = 0;
  logic        rstN, endianSel, narrowSel, sizeSel, selN, rdEn, fifoValid;
  logic [35:0] fifoData;
  logic        fifoPop, outValid;
  logic [35:0] outData;
  logic [35:0] words [4];
  int          ptr;
  int          total = 0;
  int          bad = 0;

  always #2.5 clk = ~clk;

  assign fifoData = words[ptr];

  busWidthMatcher uut (
    .clk(clk), .rstN(rstN), .endianSel(endianSel), .narrowSel(narrowSel),
    .sizeSel(sizeSel), .selN(selN), .rdEn(rdEn), .fifoData(fifoData),
    .fifoValid(fifoValid), .fifoPop(fifoPop), .outData(outData),
    .outValid(outValid)
  );

  function automatic logic [35:0] byteOf(input logic [35:0] w, input int n);
    return {27'b0, w[9*n +: 9]};
  endfunction

  function automatic logic [35:0] wordOf(input logic [35:0] w, input int n);
    return {18'b0, w[18*n +: 18]};
  endfunction

  task automatic chk(input bit ok, input string tag,
                     input logic [35:0] act, input logic [35:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reset with the given order and mode, then flip the endian pin (R5).
  task automatic doReset(input logic bigE, input logic nar, input logic siz);
    @(negedge clk);
    rstN = 0; endianSel = bigE; narrowSel = nar; sizeSel = siz;
    selN = 1; rdEn = 0; fifoValid = 1; ptr = 0;
    repeat (2) @(negedge clk);
    rstN = 1;
    endianSel = ~bigE;
  endtask

  // One accepted read, starting and ending at a falling edge.
  task automatic readStep(input logic [35:0] expOut, input logic expPop,
                          input string tag);
    selN = 0; rdEn = 1;
    #1;
    chk(outData === expOut, tag, outData, expOut);
    chk(fifoPop === expPop, {tag, " pop"}, 36'(fifoPop), 36'(expPop));
    @(negedge clk);
    selN = 1; rdEn = 0;
    if (expPop) ptr = (ptr + 1) % 4;
  endtask

  task automatic testReset;
    doReset(1'b0, 1'b1, 1'b1);
    #1;
    chk(outData === byteOf(words[0], 0), "R9 first piece", outData, byteOf(words[0], 0));
    chk(fifoPop === 1'b0, "R9 idle pop", 36'(fifoPop), 36'd0);
    chk(outValid === 1'b1, "R8 valid pass", 36'(outValid), 36'd1);
  endtask

  task automatic testByte(input logic bigE);
    doReset(bigE, 1'b1, 1'b1);
    for (int w = 0; w < 2; w++)
      for (int k = 0; k < 4; k++)
        readStep(byteOf(words[w], bigE ? 3 - k : k), k == 3,
                 bigE ? "R4 R5 R7 byte big" : "R2 R7 byte little");
  endtask

  task automatic testWord(input logic bigE);
    doReset(bigE, 1'b1, 1'b0);
    for (int w = 0; w < 3; w++)
      for (int k = 0; k < 2; k++)
        readStep(wordOf(words[w], bigE ? 1 - k : k), k == 1,
                 bigE ? "R3 R4 word big" : "R3 R7 word little");
  endtask

  task automatic testLong(input logic bigE);
    doReset(bigE, 1'b0, 1'b0);
    for (int w = 0; w < 3; w++)
      readStep(words[w], 1'b1, "R1 long");
  endtask

  task automatic blockedEdge(input logic s, input logic e, input string tag);
    selN = s; rdEn = e;
    #1;
    chk(fifoPop === 1'b0, tag, 36'(fifoPop), 36'd0);
    @(negedge clk);
    selN = 1; rdEn = 0;
  endtask

  task automatic testGating;
    doReset(1'b0, 1'b1, 1'b1);
    readStep(byteOf(words[0], 0), 1'b0, "R6 piece0");
    blockedEdge(1'b1, 1'b1, "R6 chip select high");
    blockedEdge(1'b0, 1'b0, "R6 enable low");
    readStep(byteOf(words[0], 1), 1'b0, "R6 position kept");
    readStep(byteOf(words[0], 2), 1'b0, "R6 piece2");
    blockedEdge(1'b1, 1'b1, "R6 gated last piece");
    readStep(byteOf(words[0], 3), 1'b1, "R6 last piece pops");
    readStep(byteOf(words[1], 0), 1'b0, "R6 next word");
  endtask

  task automatic testEmpty;
    doReset(1'b1, 1'b1, 1'b0);
    readStep(wordOf(words[0], 1), 1'b0, "R8 first half");
    fifoValid = 0;
    selN = 0; rdEn = 1;
    #1;
    chk(outValid === 1'b0, "R8 valid low", 36'(outValid), 36'd0);
    chk(fifoPop === 1'b0, "R8 empty pop", 36'(fifoPop), 36'd0);
    @(negedge clk);
    selN = 1; rdEn = 0; fifoValid = 1;
    readStep(wordOf(words[0], 0), 1'b1, "R8 position kept");
  endtask

  initial begin
    words[0] = {9'h1F1, 9'h0E2, 9'h1D3, 9'h0C4};
    words[1] = {9'h155, 9'h0AA, 9'h1B6, 9'h049};
    words[2] = {9'h007, 9'h1F8, 9'h123, 9'h0DC};
    words[3] = {9'h0F0, 9'h10F, 9'h033, 9'h1CC};
    ptr = 0;
    rstN = 0; endianSel = 0; narrowSel = 0; sizeSel = 0;
    selN = 1; rdEn = 0; fifoValid = 0;
    testReset();
    testByte(1'b0);
    testByte(1'b1);
    testWord(1'b0);
    testWord(1'b1);
    testLong(1'b0);
    testLong(1'b1);
    testGating();
    testEmpty();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule